// File: doc/BRIEF.md
# Keyboard Controller Command Decoder

This block is the host-facing register logic of a legacy PC keyboard and pointing-device controller. The host writes bytes to a command port and a data port. The block decodes each command byte and keeps three registers: an 8-bit mode register, a status register and an output-port register. It answers query commands by pushing a reply byte, tagged keyboard-side or auxiliary-side, onto a response queue interface. It also drives the A20 gate level, a one-cycle system-reset request and a one-cycle error flag for unrecognised commands.

Some commands do not act at once. Instead they arm a pending-write state, and the next data-port byte is redirected to the mode register, to the output port, to the reply queue or to the mouse. A data byte that arrives with nothing pending goes to the keyboard. The keyboard and mouse protocols are outside this block and show up here only as byte-forwarding strobes. All outputs are registered, so each effect appears one clock after the write strobe that causes it.

Top module: `kbc_cmd_decoder`

## Requirements
- R1: After reset the mode register reads 0x03, the status byte reads 0x18 (bit 3 last-write-was-command, bit 4 unlocked), the output port reads 0xCF, A20 is high, the translation output is low, and no strobe or pulse is active.
- R2: Command 0x20 replies with the current mode register and command 0xD0 replies with the current output port. Both replies are keyboard-side (reply aux flag 0).
- R3: Command 0xAA sets status bit 2 and replies 0x55. Commands 0xA9 and 0xAB reply 0x00. Command 0xC0 replies 0x80. All of these are keyboard-side.
- R4: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4. No other mode bit changes.
- R5: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 arm a pending write. The next data byte then does one thing: it is written to the mode register (0x60), written to the output port (0xD1), replied keyboard-side (0xD2), replied with aux flag 1 (0xD3), or forwarded on the mouse strobe (0xD4). The data byte consumes the pending state.
- R6: A data byte with nothing pending is forwarded on the keyboard strobe and produces no reply.
- R7: A command with upper nibble 0xF whose bit 0 is 0 gives a one-cycle system-reset pulse. A command with upper nibble 0xF whose bit 0 is 1 has no effect.
- R8: Command 0xDF sets output-port bit 1 and raises A20. Command 0xDD clears that bit and lowers A20.
- R9: A data byte written to the output port sets A20 from its bit 1. If its bit 0 is 0, it also gives a one-cycle system-reset pulse.
- R10: The translation output follows mode bit 6.
- R11: An unrecognised command gives a one-cycle error pulse and changes nothing else. Registers, status and any armed pending write all stay as they were.
- R12: Status bit 3 is set by each recognised command write and cleared by each data write. Any recognised command that does not arm a pending write cancels one that is armed.
- R13: When a command write and a data write happen in the same cycle, the command is executed and the data byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command port write strobe |
| cmd_byte | input | 8 | Command byte |
| data_wr | input | 1 | Data port write strobe |
| data_byte | input | 8 | Data byte |
| status_o | output | 8 | Status register |
| mode_o | output | 8 | Mode register |
| outport_o | output | 8 | Output-port register |
| xlate_o | output | 1 | Scan-code translation select (mode bit 6) |
| a20_o | output | 1 | A20 gate level |
| sys_reset_o | output | 1 | One-cycle system-reset request |
| bad_cmd_o | output | 1 | One-cycle unrecognised-command flag |
| rsp_valid_o | output | 1 | Reply byte push strobe |
| rsp_aux_o | output | 1 | Reply belongs to the auxiliary side |
| rsp_byte_o | output | 8 | Reply byte |
| kbd_tx_valid_o | output | 1 | Forward byte to keyboard |
| aux_tx_valid_o | output | 1 | Forward byte to mouse |
| tx_byte_o | output | 8 | Forwarded byte |

## Verification
A command-port write and a data-port write can fall in the same cycle. This matters most when a pending write is armed, because the command may then cancel or replace the pending target while the data byte tries to consume it. The bench arms mode-register and keyboard-reply writes and then raises both strobes together. It checks that only the command's effect appears and that the data byte leaves no mark. A follow-up data byte must then go to the keyboard, which shows that the old pending state was dropped.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;

  // mode bit masks decoded by neighbouring interrupt and port logic
  localparam logic [BYTE_W-1:0] MODE_KBD_OFF   = 8'h10;
  localparam logic [BYTE_W-1:0] MODE_MOUSE_OFF = 8'h20;
  localparam int               MODE_XLATE_BIT  = 6;
  localparam int               OUTP_A20_BIT    = 1;

  typedef enum logic [2:0] {
    PW_NONE, PW_MODE, PW_OUTP, PW_KBUF, PW_ABUF, PW_MOUSE
  } pend_e;

  typedef enum logic [1:0] {
    RS_NONE, RS_CONST, RS_MODE, RS_OUTP
  } rsrc_e;

  typedef struct packed {
    logic              known;
    rsrc_e             rsrc;
    logic [BYTE_W-1:0] rconst;
    pend_e             arm;
    logic [BYTE_W-1:0] mset;
    logic [BYTE_W-1:0] mclr;
    logic              a20_on;
    logic              a20_off;
    logic              selftest;
    logic              cpu_rst;
  } cmd_act_t;

  typedef struct packed {
    logic to_mode;
    logic to_outp;
    logic to_kq;
    logic to_aq;
    logic to_mouse;
    logic to_kbd;
  } route_t;

  function automatic logic is_pulse_cmd(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: 4] == 4'hF;
  endfunction

  function automatic logic pulse_resets_cpu(input logic [BYTE_W-1:0] b);
    return is_pulse_cmd(b) && !b[0];
  endfunction

  function automatic logic [BYTE_W-1:0] apply_mode_mask(
      input logic [BYTE_W-1:0] m, input logic [BYTE_W-1:0] s,
      input logic [BYTE_W-1:0] c);
    return (m | s) & ~c;
  endfunction

  function automatic logic outp_requests_reset(input logic [BYTE_W-1:0] v);
    return !v[0];
  endfunction
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
  import kbc_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_byte,
  output cmd_act_t          act
);
  always_comb begin
    act       = '0;
    act.known = 1'b1;
    act.arm   = PW_NONE;
    act.rsrc  = RS_NONE;
    if (is_pulse_cmd(cmd_byte)) begin
      act.cpu_rst = pulse_resets_cpu(cmd_byte);
    end else begin
      unique case (cmd_byte)
        8'h20: act.rsrc = RS_MODE;
        8'hD0: act.rsrc = RS_OUTP;
        8'h60: act.arm  = PW_MODE;
        8'hD1: act.arm  = PW_OUTP;
        8'hD2: act.arm  = PW_KBUF;
        8'hD3: act.arm  = PW_ABUF;
        8'hD4: act.arm  = PW_MOUSE;
        8'hA7: act.mset = MODE_MOUSE_OFF;
        8'hA8: act.mclr = MODE_MOUSE_OFF;
        8'hAD: act.mset = MODE_KBD_OFF;
        8'hAE: act.mclr = MODE_KBD_OFF;
        8'hA9, 8'hAB: begin
          act.rsrc   = RS_CONST;
          act.rconst = 8'h00;
        end
        8'hAA: begin
          act.rsrc     = RS_CONST;
          act.rconst   = 8'h55;
          act.selftest = 1'b1;
        end
        8'hC0: begin
          act.rsrc   = RS_CONST;
          act.rconst = 8'h80;
        end
        8'hDD: act.a20_off = 1'b1;
        8'hDF: act.a20_on  = 1'b1;
        default: act.known = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/kbc_pend_route.sv
module kbc_pend_route
  import kbc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cmd_ok,
  input  pend_e  arm,
  input  logic   data_go,
  output pend_e  pend_q,
  output route_t route
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= PW_NONE;
    else if (cmd_ok)  pend_q <= arm;
    else if (data_go) pend_q <= PW_NONE;
  end

  always_comb begin
    route          = '0;
    route.to_mode  = data_go && pend_q == PW_MODE;
    route.to_outp  = data_go && pend_q == PW_OUTP;
    route.to_kq    = data_go && pend_q == PW_KBUF;
    route.to_aq    = data_go && pend_q == PW_ABUF;
    route.to_mouse = data_go && pend_q == PW_MOUSE;
    route.to_kbd   = data_go && pend_q == PW_NONE;
  end
endmodule

// File: rtl/kbc_ctrl_regs.sv
module kbc_ctrl_regs
  import kbc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MODE_INIT = 8'h03,
  parameter logic [BYTE_W-1:0] OUTP_INIT = 8'hCF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_ok,
  input  cmd_act_t          act,
  input  logic              data_go,
  input  route_t            route,
  input  logic [BYTE_W-1:0] data_byte,
  output logic [BYTE_W-1:0] mode_q,
  output logic [BYTE_W-1:0] outp_q,
  output logic              a20_q,
  output logic              selftest_q,
  output logic              lastcmd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_INIT;
      outp_q     <= OUTP_INIT;
      a20_q      <= OUTP_INIT[OUTP_A20_BIT];
      selftest_q <= 1'b0;
      lastcmd_q  <= 1'b1;
    end else if (cmd_ok) begin
      mode_q    <= apply_mode_mask(mode_q, act.mset, act.mclr);
      lastcmd_q <= 1'b1;
      if (act.selftest) selftest_q <= 1'b1;
      if (act.a20_on) begin
        outp_q[OUTP_A20_BIT] <= 1'b1;
        a20_q                <= 1'b1;
      end else if (act.a20_off) begin
        outp_q[OUTP_A20_BIT] <= 1'b0;
        a20_q                <= 1'b0;
      end
    end else if (data_go) begin
      lastcmd_q <= 1'b0;
      if (route.to_mode) mode_q <= data_byte;
      if (route.to_outp) begin
        outp_q <= data_byte;
        a20_q  <= data_byte[OUTP_A20_BIT];
      end
    end
  end
endmodule

// File: rtl/kbc_cmd_decoder.sv
module kbc_cmd_decoder
  import kbc_pkg::*;
#(
  parameter logic [7:0] MODE_INIT = 8'h03,
  parameter logic [7:0] OUTP_INIT = 8'hCF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  input  logic       data_wr,
  input  logic [7:0] data_byte,
  output logic [7:0] status_o,
  output logic [7:0] mode_o,
  output logic [7:0] outport_o,
  output logic       xlate_o,
  output logic       a20_o,
  output logic       sys_reset_o,
  output logic       bad_cmd_o,
  output logic       rsp_valid_o,
  output logic       rsp_aux_o,
  output logic [7:0] rsp_byte_o,
  output logic       kbd_tx_valid_o,
  output logic       aux_tx_valid_o,
  output logic [7:0] tx_byte_o
);
  cmd_act_t act;
  route_t   route;
  pend_e    pend_q;
  logic     cmd_ok, cmd_bad, data_go;
  logic     selftest_q, lastcmd_q;
  logic     rsp_next, rst_next;
  logic [BYTE_W-1:0] rsp_sel;

  // a command in the same cycle wins; the data byte is dropped
  assign cmd_ok  = cmd_wr && act.known;
  assign cmd_bad = cmd_wr && !act.known;
  assign data_go = data_wr && !cmd_wr;

  kbc_cmd_decode u_dec (.cmd_byte(cmd_byte), .act(act));

  kbc_pend_route u_pend (
    .clk(clk), .rst_n(rst_n), .cmd_ok(cmd_ok), .arm(act.arm),
    .data_go(data_go), .pend_q(pend_q), .route(route)
  );

  kbc_ctrl_regs #(.MODE_INIT(MODE_INIT), .OUTP_INIT(OUTP_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_ok(cmd_ok), .act(act),
    .data_go(data_go), .route(route), .data_byte(data_byte),
    .mode_q(mode_o), .outp_q(outport_o), .a20_q(a20_o),
    .selftest_q(selftest_q), .lastcmd_q(lastcmd_q)
  );

  assign status_o = {3'b000, 1'b1, lastcmd_q, selftest_q, 2'b00};
  assign xlate_o  = mode_o[MODE_XLATE_BIT];

  always_comb begin
    rsp_next = 1'b0;
    rsp_sel  = data_byte;
    if (cmd_ok) begin
      unique case (act.rsrc)
        RS_CONST: begin rsp_next = 1'b1; rsp_sel = act.rconst; end
        RS_MODE:  begin rsp_next = 1'b1; rsp_sel = mode_o;     end
        RS_OUTP:  begin rsp_next = 1'b1; rsp_sel = outport_o;  end
        default:  rsp_next = 1'b0;
      endcase
    end else if (route.to_kq || route.to_aq) begin
      rsp_next = 1'b1;
    end
    rst_next = (cmd_ok && act.cpu_rst) ||
               (route.to_outp && outp_requests_reset(data_byte));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_reset_o    <= 1'b0;
      bad_cmd_o      <= 1'b0;
      rsp_valid_o    <= 1'b0;
      rsp_aux_o      <= 1'b0;
      rsp_byte_o     <= '0;
      kbd_tx_valid_o <= 1'b0;
      aux_tx_valid_o <= 1'b0;
      tx_byte_o      <= '0;
    end else begin
      sys_reset_o    <= rst_next;
      bad_cmd_o      <= cmd_bad;
      rsp_valid_o    <= rsp_next;
      rsp_aux_o      <= route.to_aq;
      rsp_byte_o     <= rsp_sel;
      kbd_tx_valid_o <= route.to_kbd;
      aux_tx_valid_o <= route.to_mouse;
      tx_byte_o      <= data_byte;
    end
  end
endmodule

// File: rtl/kbc_cmd_decoder_chk.sv
module kbc_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic       data_wr,
  input logic [7:0] status_o,
  input logic [7:0] mode_o,
  input logic [7:0] outport_o,
  input logic       a20_o,
  input logic       sys_reset_o,
  input logic       bad_cmd_o,
  input logic       rsp_valid_o,
  input logic       kbd_tx_valid_o,
  input logic       aux_tx_valid_o
);
  // R8
  a20_tracks_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a20_o == outport_o[1]);

  // R7
  reset_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_o |-> $past(cmd_wr || data_wr));

  // R11
  bad_cmd_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd_o |-> ($past(cmd_wr) && $stable(mode_o) && $stable(outport_o)
                   && $stable(status_o) && !rsp_valid_o));

  // R5
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid_o, kbd_tx_valid_o, aux_tx_valid_o}));

  // R13
  collide_drops_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && data_wr) |=> (!kbd_tx_valid_o && !aux_tx_valid_o));

  // R4
  mode_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_o) |-> $past(cmd_wr || data_wr));
endmodule

bind kbc_cmd_decoder kbc_cmd_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
  .status_o(status_o), .mode_o(mode_o), .outport_o(outport_o),
  .a20_o(a20_o), .sys_reset_o(sys_reset_o), .bad_cmd_o(bad_cmd_o),
  .rsp_valid_o(rsp_valid_o), .kbd_tx_valid_o(kbd_tx_valid_o),
  .aux_tx_valid_o(aux_tx_valid_o)
);

// File: tb/kbc_cmd_decoder_tb.sv
module kbc_cmd_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0, data_wr = 1'b0;
  logic [7:0] cmd_byte = '0, data_byte = '0;
  logic [7:0] status_o, mode_o, outport_o, rsp_byte_o, tx_byte_o;
  logic       xlate_o, a20_o, sys_reset_o, bad_cmd_o, rsp_valid_o, rsp_aux_o;
  logic       kbd_tx_valid_o, aux_tx_valid_o;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  kbc_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
    .data_wr(data_wr), .data_byte(data_byte), .status_o(status_o),
    .mode_o(mode_o), .outport_o(outport_o), .xlate_o(xlate_o),
    .a20_o(a20_o), .sys_reset_o(sys_reset_o), .bad_cmd_o(bad_cmd_o),
    .rsp_valid_o(rsp_valid_o), .rsp_aux_o(rsp_aux_o),
    .rsp_byte_o(rsp_byte_o), .kbd_tx_valid_o(kbd_tx_valid_o),
    .aux_tx_valid_o(aux_tx_valid_o), .tx_byte_o(tx_byte_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one write cycle; outputs are sampled at the following falling edge
  task automatic wr(input logic c, input logic [7:0] cb, input logic d, input logic [7:0] db);
    @(negedge clk);
    cmd_wr = c; cmd_byte = cb; data_wr = d; data_byte = db;
    @(negedge clk);
    cmd_wr = 1'b0; data_wr = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] b); wr(1'b1, b, 1'b0, 8'h00); endtask
  task automatic dat(input logic [7:0] b); wr(1'b0, 8'h00, 1'b1, b); endtask

  task automatic expect_rsp(input string tag, input logic [7:0] b, input logic aux);
    chk({tag, " rsp_valid"}, {7'd0, rsp_valid_o}, 8'd1);
    chk({tag, " rsp_byte"}, rsp_byte_o, b);
    chk({tag, " rsp_aux"}, {7'd0, rsp_aux_o}, {7'd0, aux});
  endtask

  task automatic t_reset;
    chk("R1 mode", mode_o, 8'h03);
    chk("R1 status", status_o, 8'h18);
    chk("R1 outport", outport_o, 8'hCF);
    chk("R1 a20/xlate", {6'd0, a20_o, xlate_o}, 8'h02);
    chk("R1 strobes", {2'd0, sys_reset_o, bad_cmd_o, rsp_valid_o,
                       kbd_tx_valid_o, aux_tx_valid_o, 1'b0}, 8'h00);
  endtask

  task automatic t_queries;
    cmd(8'h20); expect_rsp("R2 read mode", 8'h03, 1'b0);
    cmd(8'hD0); expect_rsp("R2 read outport", 8'hCF, 1'b0);
    cmd(8'hAA); expect_rsp("R3 self test", 8'h55, 1'b0);
    chk("R3 status selftest", status_o, 8'h1C);
    cmd(8'hA9); expect_rsp("R3 A9", 8'h00, 1'b0);
    cmd(8'hAB); expect_rsp("R3 AB", 8'h00, 1'b0);
    cmd(8'hC0); expect_rsp("R3 C0", 8'h80, 1'b0);
  endtask

  task automatic t_mode_bits;
    cmd(8'hA7); chk("R4 mouse off", mode_o, 8'h23);
    cmd(8'hAD); chk("R4 kbd off", mode_o, 8'h33);
    cmd(8'hA8); chk("R4 mouse on", mode_o, 8'h13);
    cmd(8'hAE); chk("R4 kbd on", mode_o, 8'h03);
    chk("R12 status after cmd", status_o, 8'h1C);
    dat(8'h3C);
    chk("R6 kbd fwd", {7'd0, kbd_tx_valid_o}, 8'd1);
    chk("R6 fwd byte", tx_byte_o, 8'h3C);
    chk("R6 no reply", {7'd0, rsp_valid_o}, 8'd0);
    chk("R12 status after data", status_o, 8'h14);
  endtask

  task automatic t_two_step;
    cmd(8'h60); dat(8'h47);
    chk("R5 mode write", mode_o, 8'h47);
    chk("R10 xlate on", {7'd0, xlate_o}, 8'd1);
    chk("R5 no kbd fwd", {7'd0, kbd_tx_valid_o}, 8'd0);
    dat(8'h12);
    chk("R5 pending consumed", {7'd0, kbd_tx_valid_o}, 8'd1);
    chk("R5 mode kept", mode_o, 8'h47);
    cmd(8'h60); dat(8'h03);
    chk("R10 xlate off", {7'd0, xlate_o}, 8'd0);
    cmd(8'hD2); dat(8'hAB); expect_rsp("R5 kbd buf", 8'hAB, 1'b0);
    cmd(8'hD3); dat(8'h5A); expect_rsp("R5 aux buf", 8'h5A, 1'b1);
    cmd(8'hD4); dat(8'hF4);
    chk("R5 mouse fwd", {6'd0, aux_tx_valid_o, kbd_tx_valid_o}, 8'h02);
    chk("R5 mouse byte", tx_byte_o, 8'hF4);
  endtask

  task automatic t_unknown;
    cmd(8'h55);
    chk("R11 bad pulse", {7'd0, bad_cmd_o}, 8'd1);
    chk("R11 no reply", {7'd0, rsp_valid_o}, 8'd0);
    chk("R11 status kept", status_o, 8'h14);
    chk("R11 mode kept", mode_o, 8'h03);
    @(negedge clk);
    chk("R11 pulse ends", {7'd0, bad_cmd_o}, 8'd0);
    cmd(8'h60); cmd(8'h01); dat(8'h11);
    chk("R11 pending survives", mode_o, 8'h11);
    cmd(8'h60); dat(8'h03);
  endtask

  task automatic t_outport;
    cmd(8'hD1); dat(8'hCD);
    chk("R9 port write", outport_o, 8'hCD);
    chk("R9 a20 low/no reset", {6'd0, a20_o, sys_reset_o}, 8'h00);
    cmd(8'hD1); dat(8'hCE);
    chk("R9 a20 high + reset", {6'd0, a20_o, sys_reset_o}, 8'h03);
    cmd(8'hD1); dat(8'hCF);
    chk("R9 no reset", {7'd0, sys_reset_o}, 8'd0);
    cmd(8'hD0); expect_rsp("R2 outport after write", 8'hCF, 1'b0);
  endtask

  task automatic t_a20;
    cmd(8'hDD);
    chk("R8 a20 off", {7'd0, a20_o}, 8'd0);
    chk("R8 port bit off", outport_o, 8'hCD);
    cmd(8'hDF);
    chk("R8 a20 on", {7'd0, a20_o}, 8'd1);
    chk("R8 port bit on", outport_o, 8'hCF);
  endtask

  task automatic t_pulse;
    cmd(8'hFE); chk("R7 FE resets", {7'd0, sys_reset_o}, 8'd1);
    @(negedge clk); chk("R7 one cycle", {7'd0, sys_reset_o}, 8'd0);
    cmd(8'hFF); chk("R7 FF no-op", {6'd0, sys_reset_o, bad_cmd_o}, 8'd0);
    cmd(8'hF0); chk("R7 F0 resets", {7'd0, sys_reset_o}, 8'd1);
    cmd(8'hF1); chk("R7 F1 no-op", {6'd0, sys_reset_o, bad_cmd_o}, 8'd0);
    chk("R7 regs kept", outport_o, 8'hCF);
  endtask

  task automatic t_collide;
    cmd(8'h60);
    wr(1'b1, 8'hAD, 1'b1, 8'h77);
    chk("R13 command wins", mode_o, 8'h13);
    chk("R13 data dropped", {6'd0, kbd_tx_valid_o, aux_tx_valid_o}, 8'd0);
    dat(8'h21);
    chk("R12 pending cancelled", {7'd0, kbd_tx_valid_o}, 8'd1);
    chk("R12 mode kept", mode_o, 8'h13);
    cmd(8'hAE);
    cmd(8'hD2);
    wr(1'b1, 8'h20, 1'b1, 8'h99);
    expect_rsp("R13 reply from command", 8'h03, 1'b0);
    dat(8'h44);
    chk("R13 old pending gone", {7'd0, kbd_tx_valid_o}, 8'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_queries();
    t_mode_bits();
    t_two_step();
    t_unknown();
    t_outport();
    t_a20();
    t_pulse();
    t_collide();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule